// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a small serial EEPROM holding 256 bytes. A fast system clock oversamples the bus clock and data lines. The block finds START, repeated START and STOP conditions and answers to one 7-bit device address. It takes word-addressed writes of any length and serves random, current-address and sequential reads from one word pointer. SDA is open-drain: the block only ever asserts a pull-low enable and never drives the line high.

Written bytes are held in a staging store and reach the memory only when a STOP closes the write. The block then runs an internal write cycle lasting a set number of system clocks. During that cycle it refuses its own address, so a controller can poll it to find out when the cycle is over.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the pull-low output is released and every memory location reads back as 0x00.
- R2: A START (SDA falling while SCL is high) and a STOP (SDA rising while SCL is high) are recognised at any bit position, and a START restarts address reception. The target changes its pull-low only after a falling SCL edge, except that it releases at START or STOP.
- R3: In the first byte after a START, bits 7:1 hold the device address (default 7'b1010000) and bit 0 holds the direction (0 write, 1 read). On a match the target pulls SDA low for the whole ninth clock. On a mismatch it gives no acknowledge and ignores every following byte until the next START or STOP.
- R4: In a write, the byte after the address sets the word pointer. Each following data byte (MSB first) is acknowledged and stored at the next address in turn.
- R5: Staged data bytes are committed only by a STOP. A START that arrives before the STOP discards them.
- R6: A random read (write-direction address, word address, repeated START, read-direction address) returns the byte at that word address, MSB first.
- R7: During a read, a low controller acknowledge makes the target send the next byte. A high one (NACK) makes it release SDA and wait for STOP or START.
- R8: The word pointer steps by one after each data byte written or sent, and wraps from 255 to 0.
- R9: A write-direction address with no word-address byte leaves the pointer unchanged. A read with no word address starts at the current pointer.
- R10: After a STOP that ends a write carrying data, the target refuses its address for WRITE_CYCLES system clocks and acknowledges it again afterwards.
- R11: A STOP ending a write with no data byte does not start the internal write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_pull_low | output | 1 | When high, the pad pulls SDA to ground |

## Verification
The main function is tried with several kinds of traffic:
- a multi-byte write and a three-byte sequential read of the same bytes, which separates correct address stepping and bit order from shifted or reversed data;
- a write starting at 0xFE, read back across the top address, which shows whether the pointer wraps or saturates;
- an address-only write followed at once by a current-address read, which shows that the pointer is kept and that no write cycle was started;
- data followed by a repeated START, which tells commit-at-STOP apart from commit-per-byte;
- traffic to a foreign address, which must leave the pointer alone;
- a START cut into a half-sent address byte, followed by a normal transaction;
- a poll straight after a write, and another after the cycle has ended, which locate the window in which the address is refused.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WORD,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  // Device address lives in bits 7:1 of the first byte.
  function automatic logic dev_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Level of the bit sent in slot idx, slot 0 being the MSB.
  function automatic logic tx_level(input logic [7:0] b, input logic [2:0] idx);
    return b[3'd7 - idx];
  endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic prev,
  output logic rise,
  output logic fall
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b1;
      lvl  <= 1'b1;
      prev <= 1'b1;
    end else begin
      meta <= raw;
      lvl  <= meta;
      prev <= lvl;
    end
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CYCLES = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // Independent span counter for the checker.
  logic [31:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 32'(CYCLES)); // R10
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_we,
  input  logic [$clog2(DEPTH)-1:0] st_addr,
  input  logic [7:0]               st_data,
  input  logic                     discard,
  input  logic                     commit,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  output logic                     pending
);
  logic [7:0]       mem   [DEPTH];
  logic [7:0]       stage [DEPTH];
  logic [DEPTH-1:0] dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      dirty <= '0;
    end else if (discard) begin
      dirty <= '0;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++)
        if (dirty[i]) mem[i] <= stage[i];
      dirty <= '0;
    end else if (st_we) begin
      dirty[st_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_we) stage[st_addr] <= st_data;
  end

  assign rd_data = mem[rd_addr];
  assign pending = |dirty;

  AST_DISCARD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !pending); // R5
  AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pending); // R5
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'b1010000,
  parameter int         WRITE_CYCLES = 150000,
  parameter int         MEM_DEPTH    = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_low
);
  localparam int AW = $clog2(MEM_DEPTH);

  logic scl_s, scl_p, scl_rise, scl_fall;
  logic sda_s, sda_p, sda_rise, sda_fall;

  eep_line_sync u_scl (.clk(clk), .rst_n(rst_n), .raw(scl_i),
                       .lvl(scl_s), .prev(scl_p), .rise(scl_rise), .fall(scl_fall));
  eep_line_sync u_sda (.clk(clk), .rst_n(rst_n), .raw(sda_i),
                       .lvl(sda_s), .prev(sda_p), .rise(sda_rise), .fall(sda_fall));

  // Named bus events
  logic start_ev, stop_ev;
  assign start_ev = scl_s & scl_p & sda_fall;
  assign stop_ev  = scl_s & scl_p & sda_rise;

  phase_t        phase;
  logic [3:0]    bitcnt;
  logic          in_ack, nack, drv;
  logic [7:0]    rx_sh, tx_sh;
  logic [AW-1:0] ptr;
  logic [7:0]    rd_data;
  logic          pending, busy;

  // Named internal events
  logic byte_end, addr_decide, st_we;
  assign byte_end    = scl_fall && bitcnt == 4'd8 && !in_ack && !start_ev && !stop_ev;
  assign addr_decide = byte_end && phase == PH_DEV;
  assign st_we       = byte_end && phase == PH_WDATA;

  eep_store #(.DEPTH(MEM_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .st_we(st_we), .st_addr(ptr), .st_data(rx_sh),
    .discard(start_ev), .commit(stop_ev),
    .rd_addr(ptr), .rd_data(rd_data), .pending(pending));

  eep_busy_timer #(.CYCLES(WRITE_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(stop_ev && pending), .busy(busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      nack   <= 1'b1;
      drv    <= 1'b0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      ptr    <= '0;
    end else if (start_ev) begin
      phase  <= PH_DEV;
      bitcnt <= '0;
      in_ack <= 1'b0;
      drv    <= 1'b0;
    end else if (stop_ev) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      drv    <= 1'b0;
    end else begin
      case (phase)
        PH_DEV, PH_WORD, PH_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            rx_sh  <= {rx_sh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (scl_fall && bitcnt == 4'd8) begin
            if (!in_ack) begin
              if (phase == PH_DEV) begin
                if (dev_hit(rx_sh, DEV_ADDR) && !busy) begin
                  drv    <= 1'b1;
                  in_ack <= 1'b1;
                end else begin
                  phase <= PH_SKIP;
                end
              end else begin
                drv    <= 1'b1;
                in_ack <= 1'b1;
                if (phase == PH_WORD) ptr <= rx_sh[AW-1:0];
                else                  ptr <= ptr + 1'b1;
              end
            end else begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              drv    <= 1'b0;
              if (phase == PH_DEV) begin
                if (rx_sh[0]) begin
                  phase <= PH_RDATA;
                  tx_sh <= rd_data;
                  drv   <= ~tx_level(rd_data, 3'd0);
                end else begin
                  phase <= PH_WORD;
                end
              end else if (phase == PH_WORD) begin
                phase <= PH_WDATA;
              end
            end
          end
        end
        PH_RDATA: begin
          if (scl_rise) begin
            if (bitcnt < 4'd8) bitcnt <= bitcnt + 1'b1;
            else if (in_ack)   nack <= sda_s;
          end
          if (scl_fall) begin
            if (bitcnt < 4'd8) begin
              drv <= ~tx_level(tx_sh, bitcnt[2:0]);
            end else if (!in_ack) begin
              drv    <= 1'b0;
              in_ack <= 1'b1;
              ptr    <= ptr + 1'b1;
            end else begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              if (nack) begin
                phase <= PH_SKIP;
                drv   <= 1'b0;
              end else begin
                tx_sh <= rd_data;
                drv   <= ~tx_level(rd_data, 3'd0);
              end
            end
          end
        end
        default: drv <= 1'b0;
      endcase
    end
  end

  assign sda_pull_low = drv;

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv) |-> $past(scl_fall || start_ev || stop_ev)); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !drv); // R2
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    addr_decide && busy |=> !drv && phase == PH_SKIP); // R10
  AST_FOREIGN_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_decide && !dev_hit(rx_sh, DEV_ADDR) |=> !drv && phase == PH_SKIP); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> ptr == $past(ptr) + AW'(1)); // R8
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SKIP && $past(phase == PH_SKIP) |-> !drv); // R7
endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 8;
  localparam int WC = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_ctrl = 1'b1;
  logic drv;
  wire  sda_line = sda_ctrl & ~drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_target #(.WRITE_CYCLES(WC)) i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_low(drv));

  int vectors = 0, miscmp = 0;
  bit done = 1'b0;

  // Reference model state
  int ref_mem [256];
  int ref_ptr = 0;
  int st_a[$], st_d[$];
  bit ref_busy = 1'b0;

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock monitor: drive must hold while SCL is high (R2)
  logic scl_q = 1'b1, drv_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_q) begin
      vectors++;
      if (drv !== drv_q) begin
        miscmp++;
        $display("FAIL R2 drive moved during SCL high actual=%0b expected=%0b", drv, drv_q);
      end
    end
    scl_q = scl;
    drv_q = drv;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic seen);
    sda_ctrl = b; wq(Q);
    scl = 1'b1;   wq(Q);
    seen = sda_line; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_start();
    sda_ctrl = 1'b1; wq(Q);
    scl = 1'b1;      wq(Q);
    sda_ctrl = 1'b0; wq(Q);
    scl = 1'b0;      wq(Q);
    st_a.delete(); st_d.delete();
  endtask

  task automatic bus_stop();
    sda_ctrl = 1'b0; wq(Q);
    scl = 1'b1;      wq(Q);
    sda_ctrl = 1'b1; wq(2*Q);
    if (st_a.size() > 0) ref_busy = 1'b1;
    foreach (st_a[k]) ref_mem[st_a[k]] = st_d[k];
    st_a.delete(); st_d.delete();
  endtask

  task automatic send_byte(input logic [7:0] b, input int exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    check(int'(!s), exp_ack, tag);
  endtask

  task automatic recv_byte(input logic more, input string tag);
    logic s;
    logic [7:0] d = '0;
    int exp;
    for (int i = 0; i < 8; i++) begin
      put_bit(1'b1, s);
      d = {d[6:0], s};
    end
    put_bit(!more, s);
    exp = ref_mem[ref_ptr];
    ref_ptr = (ref_ptr + 1) % 256;
    check(int'(d), exp, tag);
  endtask

  task automatic wdata(input int v, input string tag);
    send_byte(8'(v), 1, tag);
    st_a.push_back(ref_ptr); st_d.push_back(v);
    ref_ptr = (ref_ptr + 1) % 256;
  endtask

  task automatic waddr(input int a, input string tag);
    send_byte(8'(a), 1, tag);
    ref_ptr = a;
  endtask

  task automatic wait_cycle();
    wq(WC + 100);
    ref_busy = 1'b0;
  endtask

  initial begin
    logic s;
    foreach (ref_mem[k]) ref_mem[k] = 0;
    wq(5);
    check(int'(drv), 0, "R1 released in reset");
    rst_n = 1'b1; wq(5);
    check(int'(drv), 0, "R1 released after reset");

    // Random read of untouched location
    bus_start(); send_byte(8'hA0, 1, "R3 address ack"); waddr(8'h10, "R4 word ack");
    bus_start(); send_byte(8'hA1, 1, "R6 read address ack");
    recv_byte(1'b0, "R1 empty memory"); bus_stop();

    // Multi-byte write
    bus_start(); send_byte(8'hA0, 1, "R4 address ack"); waddr(8'h10, "R4 word ack");
    wdata(8'hA5, "R4 data0"); wdata(8'h3C, "R4 data1");
    wdata(8'h0F, "R4 data2"); wdata(8'h77, "R4 data3"); bus_stop();

    // Poll during write cycle
    bus_start(); send_byte(8'hA0, ref_busy ? 0 : 1, "R10 busy poll refused"); bus_stop();
    wait_cycle();

    // Sequential read
    bus_start(); send_byte(8'hA0, 1, "R10 ack after cycle"); waddr(8'h10, "R6 word ack");
    bus_start(); send_byte(8'hA1, 1, "R6 read address ack");
    recv_byte(1'b1, "R6 first byte"); recv_byte(1'b1, "R7 next byte");
    recv_byte(1'b0, "R7 last byte"); bus_stop();
    check(int'(drv), 0, "R7 released after NACK");

    // Foreign address traffic
    bus_start(); send_byte(8'hA2, 0, "R3 foreign address no ack");
    send_byte(8'h00, 0, "R3 ignored byte"); send_byte(8'hEE, 0, "R3 ignored byte2"); bus_stop();
    bus_start(); send_byte(8'hA1, 1, "R9 current read ack");
    recv_byte(1'b0, "R9 pointer kept"); bus_stop();

    // Wrap across top address
    bus_start(); send_byte(8'hA0, 1, "R8 address ack"); waddr(8'hFE, "R8 word ack");
    wdata(8'h11, "R8 fe"); wdata(8'h22, "R8 ff"); wdata(8'h33, "R8 wrap 00");
    wdata(8'h44, "R8 01"); bus_stop(); wait_cycle();
    bus_start(); send_byte(8'hA0, 1, "R8 address ack"); waddr(8'hFF, "R8 word ack");
    bus_start(); send_byte(8'hA1, 1, "R8 read ack");
    recv_byte(1'b1, "R8 read ff"); recv_byte(1'b0, "R8 read wraps to 00"); bus_stop();

    // Address-only write: pointer kept, no write cycle
    bus_start(); send_byte(8'hA0, 1, "R9 address-only ack"); bus_stop();
    bus_start(); send_byte(8'hA1, ref_busy ? 0 : 1, "R11 no write cycle");
    recv_byte(1'b0, "R9 current address read"); bus_stop();

    // Data dropped by repeated START
    bus_start(); send_byte(8'hA0, 1, "R5 address ack"); waddr(8'h10, "R5 word ack");
    wdata(8'h99, "R5 staged data");
    bus_start(); send_byte(8'hA1, 1, "R5 read ack");
    recv_byte(1'b0, "R5 neighbour unchanged"); bus_stop();
    bus_start(); send_byte(8'hA0, ref_busy ? 0 : 1, "R5 no write cycle"); waddr(8'h10, "R5 word");
    bus_start(); send_byte(8'hA1, 1, "R5 read ack");
    recv_byte(1'b0, "R5 old data kept"); bus_stop();

    // START inside a half-sent byte
    bus_start();
    for (int i = 0; i < 4; i++) put_bit(i[0] ? 1'b0 : 1'b1, s);
    bus_start(); send_byte(8'hA0, 1, "R2 restart address ack"); waddr(8'h12, "R2 word ack");
    bus_start(); send_byte(8'hA1, 1, "R2 read ack");
    recv_byte(1'b0, "R2 data after restart"); bus_stop();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule